// File: doc/BRIEF.md
# Programmable Chip-Select and Ready Generator

This block turns each bus access, made of a 20-bit byte address and a flag that marks memory or IO space, into active-low select strobes. There are thirteen of them: one for a region at the top of memory, one for a region that begins at address zero, four for the quarters of a relocatable mid-range memory block, and seven for adjacent 128-byte peripheral windows. The peripheral windows can sit in either memory or IO space. A small register port holds the layout of every region and its ready behaviour.

For each access the block also produces the bus ready. It counts wait states from the start of the bus cycle up to the count stored for the region that was hit. Depending on a per-region bit, it either ignores the external ready input or requires that input as well. Coming out of reset, only the top region is enabled: a 1K block with three wait states and external ready honoured. Every other region stays silent until software writes its register.

Top module: `csel_ready_gen`

## Requirements
- R1: While rst is high, every chip-select output is high and rdy is low.
- R2: After reset the top-region register (index 0) reads 0xFFFB, so the top select covers memory addresses 0xFFC00 to 0xFFFFF with 3 wait states and external ready honoured.
- R3: The lower, mid-range and peripheral selects stay high until their registers have been written. The mid-range block needs both its base (index 2) and its size (index 3) register written.
- R4: Top region, register index 0: bits 15:6 give address bits 19:10 of the region start. The select is low for memory accesses whose address bits 19:10 are at or above that field.
- R5: Lower region, register index 1: bits 15:6 give address bits 19:10 of the last 1K page. The select is low for memory accesses whose address bits 19:10 are at or below that field.
- R6: Mid-range block: bits 15:9 of index 2 give address bits 19:13 of the base. Bits 2:0 of index 3 give a size code k, with block size 8K shifted left by k; codes above 6 act as 6. The base and the address are compared after dropping their low k bits. mid_cs_n[i] is low when (address >> (11+k)) mod 4 equals i.
- R7: Peripheral windows, register index 4: bits 15:6 give address bits 19:10 of the base, and bit 5 selects the space (1 = IO). per_cs_n[i] is low when address bits 9:7 equal i, for i from 0 to 6. The value 7 selects nothing.
- R8: In every region register, bits 1:0 hold the wait count w and bit 2 set means external ready is ignored. Count the cycle after the edge that samples bus_start as cycle 0. With external ready high, rdy first goes high in cycle w.
- R9: With bit 2 clear, rdy stays low while ext_rdy is low, even after the count is reached, and rises in the cycle in which ext_rdy goes high. With bit 2 set, ext_rdy has no effect.
- R10: At most one select is low at a time, with priority top > lower > mid-range > peripheral. The top, lower and mid-range selects respond only to memory-space accesses.
- R11: All selects are high while bus_valid is low.
- R12: A bus cycle that starts in the same clock as a register write uses the region's ready settings from before that write.
- R13: rdy returns low in the cycle after it was high, until the next bus_start. An access that hits no region completes with 0 wait states, external ready honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| bus_valid | input | 1 | Address and space flag are valid |
| bus_start | input | 1 | First clock of a bus cycle |
| bus_io | input | 1 | 1 = IO space, 0 = memory space |
| bus_addr | input | 20 | Byte address |
| ext_rdy | input | 1 | External ready |
| up_cs_n | output | 1 | Top-region select, active low |
| lo_cs_n | output | 1 | Lower-region select, active low |
| mid_cs_n | output | 4 | Mid-range quarter selects, active low |
| per_cs_n | output | 7 | Peripheral window selects, active low |
| rdy | output | 1 | Bus ready |

## Verification
A register write and the start of a bus cycle can land in the same clock, and both touch the ready settings of the region being accessed. The bench provokes this by rewriting the lower region's wait count from 1 to 3 in the very cycle it launches an access to that region. It then expects rdy in cycle 1, which shows the old count was captured. The following access to the same region must wait until cycle 3.

// File: rtl/csel_pkg.sv
package csel_pkg;
    localparam int ADDR_W     = 20;
    localparam int DATA_W     = 16;
    localparam int WS_W       = 2;
    localparam int CFG_W      = WS_W + 1;
    localparam int RA_W       = 3;
    localparam int N_REGS     = 5;
    localparam int BLK_LG     = 10;             // 1K page granularity
    localparam int HI_W       = ADDR_W - BLK_LG;
    localparam int MID_MIN_LG = 13;             // smallest mid block: 8K
    localparam int MID_W      = ADDR_W - MID_MIN_LG;
    localparam int MID_LG     = 2;              // four quarters
    localparam int N_MID      = 1 << MID_LG;
    localparam int MAX_K      = 6;              // largest mid block: 512K
    localparam int PER_IO_BIT = 5;

    localparam int IDX_UP = 0;
    localparam int IDX_LO = 1;
    localparam int IDX_MB = 2;
    localparam int IDX_MS = 3;
    localparam int IDX_PR = 4;

    localparam logic [DATA_W-1:0] UPPER_RST = 16'hFFFB;

    typedef struct packed {
        logic            ign_ext;
        logic [WS_W-1:0] waits;
    } rdy_cfg_t;

    function automatic rdy_cfg_t cfg_of(input logic [DATA_W-1:0] r);
        return rdy_cfg_t'(r[CFG_W-1:0]);
    endfunction
endpackage

// File: rtl/csel_regs.sv
module csel_regs
    import csel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] up_q,
    output logic [DATA_W-1:0] lo_q,
    output logic [DATA_W-1:0] mb_q,
    output logic [DATA_W-1:0] ms_q,
    output logic [DATA_W-1:0] pr_q,
    output logic              lo_en,
    output logic              mid_en,
    output logic              per_en
);
    logic [N_REGS-1:0][DATA_W-1:0] r_q;
    logic [N_REGS-1:0]             seen_q;

    // Only the top region has a defined reset value; the rest hold data only.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N_REGS; i++) begin
            if (reg_wr && reg_addr == RA_W'(i))
                r_q[i] <= reg_wdata;
        end
        if (rst)
            r_q[IDX_UP] <= UPPER_RST;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else begin
            for (int i = 0; i < N_REGS; i++) begin
                if (reg_wr && reg_addr == RA_W'(i))
                    seen_q[i] <= 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < N_REGS; i++) begin
            if (reg_addr == RA_W'(i))
                reg_rdata = r_q[i];
        end
    end

    assign up_q   = r_q[IDX_UP];
    assign lo_q   = r_q[IDX_LO];
    assign mb_q   = r_q[IDX_MB];
    assign ms_q   = r_q[IDX_MS];
    assign pr_q   = r_q[IDX_PR];
    assign lo_en  = seen_q[IDX_LO];
    assign mid_en = seen_q[IDX_MB] & seen_q[IDX_MS];
    assign per_en = seen_q[IDX_PR];

    logic unused_seen;
    assign unused_seen = seen_q[IDX_UP];

    // R4
    upper_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RA_W'(IDX_UP)) |=> (up_q == $past(reg_wdata)));

    // R3
    lo_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!lo_en && !(reg_wr && reg_addr == RA_W'(IDX_LO))) |=> !lo_en);
endmodule

// File: rtl/csel_decode.sv
module csel_decode
    import csel_pkg::*;
#(
    parameter int N_PER      = 7,
    parameter int PER_WIN_LG = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_io,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] up_q,
    input  logic [DATA_W-1:0] lo_q,
    input  logic [DATA_W-1:0] mb_q,
    input  logic [DATA_W-1:0] ms_q,
    input  logic [DATA_W-1:0] pr_q,
    input  logic              lo_en,
    input  logic              mid_en,
    input  logic              per_en,
    output logic              up_sel,
    output logic              lo_sel,
    output logic [N_MID-1:0]  mid_sel,
    output logic [N_PER-1:0]  per_sel,
    output rdy_cfg_t          cfg
);
    localparam int PER_IDX_W = BLK_LG - PER_WIN_LG;

    logic [HI_W-1:0] addr_hi;
    assign addr_hi = bus_addr[ADDR_W-1:BLK_LG];

    logic up_hit, lo_hit;
    assign up_hit = !bus_io && (addr_hi >= up_q[DATA_W-1 -: HI_W]);
    assign lo_hit = lo_en && !bus_io && (addr_hi <= lo_q[DATA_W-1 -: HI_W]);

    // Mid-range block: alignment by dropping k low bits of the 8K page index.
    logic [2:0]        k;
    logic [MID_W-1:0]  a_pg, b_pg;
    logic [4:0]        sub_amt;
    logic [ADDR_W-1:0] sub_sh;
    logic [MID_LG-1:0] mid_idx;
    logic              mid_hit;
    assign k       = (ms_q[2:0] > 3'(MAX_K)) ? 3'(MAX_K) : ms_q[2:0];
    assign a_pg    = bus_addr[ADDR_W-1:MID_MIN_LG] >> k;
    assign b_pg    = mb_q[DATA_W-1 -: MID_W] >> k;
    assign sub_amt = 5'(MID_MIN_LG - MID_LG) + {2'b00, k};
    assign sub_sh  = bus_addr >> sub_amt;
    assign mid_idx = sub_sh[MID_LG-1:0];
    assign mid_hit = mid_en && !bus_io && (a_pg == b_pg);

    // Peripheral windows from one 1K-aligned base.
    logic                 per_blk;
    logic [PER_IDX_W-1:0] win;
    logic [N_PER-1:0]     per_raw;
    logic                 per_hit;
    assign per_blk = per_en && (bus_io == pr_q[PER_IO_BIT])
                   && (addr_hi == pr_q[DATA_W-1 -: HI_W]);
    assign win     = bus_addr[PER_WIN_LG +: PER_IDX_W];

    for (genvar i = 0; i < N_PER; i++) begin : g_per
        assign per_raw[i] = per_blk && (win == PER_IDX_W'(i));
    end
    assign per_hit = |per_raw;

    always_comb begin
        up_sel  = 1'b0;
        lo_sel  = 1'b0;
        mid_sel = '0;
        per_sel = '0;
        cfg     = '0;
        if (bus_valid) begin
            if (up_hit) begin
                up_sel = 1'b1;
                cfg    = cfg_of(up_q);
            end else if (lo_hit) begin
                lo_sel = 1'b1;
                cfg    = cfg_of(lo_q);
            end else if (mid_hit) begin
                mid_sel[mid_idx] = 1'b1;
                cfg              = cfg_of(mb_q);
            end else if (per_hit) begin
                per_sel = per_raw;
                cfg     = cfg_of(pr_q);
            end
        end
    end

    logic unused_dec;
    assign unused_dec = ^{up_q[DATA_W-HI_W-1:CFG_W], lo_q[DATA_W-HI_W-1:CFG_W],
                          mb_q[DATA_W-MID_W-1:CFG_W], ms_q[DATA_W-1:3],
                          pr_q[PER_IO_BIT-1:CFG_W], sub_sh[ADDR_W-1:MID_LG]};

    // R10
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({up_sel, lo_sel, mid_sel, per_sel}));

    // R10
    mem_only_chk: assert property (@(posedge clk) disable iff (rst)
        bus_io |-> !(up_sel || lo_sel || (|mid_sel)));
endmodule

// File: rtl/csel_wait.sv
module csel_wait
    import csel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bus_start,
    input  rdy_cfg_t cfg_in,
    input  logic     ext_rdy,
    output logic     rdy
);
    rdy_cfg_t        cur_q;
    logic [WS_W-1:0] cnt_q;
    logic            busy_q;

    assign rdy = busy_q && (cnt_q == cur_q.waits) && (cur_q.ign_ext || ext_rdy);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            cur_q  <= '0;
        end else if (bus_start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            cur_q  <= cfg_in;
        end else if (busy_q) begin
            if (rdy)
                busy_q <= 1'b0;
            else if (cnt_q != cur_q.waits)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q <= cur_q.waits));

    // R8
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !rdy && !bus_start && cnt_q != cur_q.waits)
        |=> (cnt_q == WS_W'($past(cnt_q) + 2'd1)));

    // R13
    rdy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (rdy && !bus_start) |=> !rdy);
endmodule

// File: rtl/csel_ready_gen.sv
module csel_ready_gen
    import csel_pkg::*;
#(
    parameter int N_PER      = 7,
    parameter int PER_WIN_LG = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              bus_valid,
    input  logic              bus_start,
    input  logic              bus_io,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              ext_rdy,
    output logic              up_cs_n,
    output logic              lo_cs_n,
    output logic [N_MID-1:0]  mid_cs_n,
    output logic [N_PER-1:0]  per_cs_n,
    output logic              rdy
);
    logic [DATA_W-1:0] up_q, lo_q, mb_q, ms_q, pr_q;
    logic              lo_en, mid_en, per_en;
    logic              up_sel, lo_sel;
    logic [N_MID-1:0]  mid_sel;
    logic [N_PER-1:0]  per_sel;
    rdy_cfg_t          cfg;

    csel_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .up_q(up_q), .lo_q(lo_q), .mb_q(mb_q), .ms_q(ms_q), .pr_q(pr_q),
        .lo_en(lo_en), .mid_en(mid_en), .per_en(per_en)
    );

    csel_decode #(.N_PER(N_PER), .PER_WIN_LG(PER_WIN_LG)) u_dec (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_io(bus_io),
        .bus_addr(bus_addr), .up_q(up_q), .lo_q(lo_q), .mb_q(mb_q),
        .ms_q(ms_q), .pr_q(pr_q), .lo_en(lo_en), .mid_en(mid_en),
        .per_en(per_en), .up_sel(up_sel), .lo_sel(lo_sel),
        .mid_sel(mid_sel), .per_sel(per_sel), .cfg(cfg)
    );

    csel_wait u_wait (
        .clk(clk), .rst(rst), .bus_start(bus_start), .cfg_in(cfg),
        .ext_rdy(ext_rdy), .rdy(rdy)
    );

    assign up_cs_n  = rst ? 1'b1 : ~up_sel;
    assign lo_cs_n  = rst ? 1'b1 : ~lo_sel;
    assign mid_cs_n = rst ? '1   : ~mid_sel;
    assign per_cs_n = rst ? '1   : ~per_sel;

    // R1
    rst_idle_chk: assert property (@(posedge clk)
        rst |-> (&{up_cs_n, lo_cs_n, mid_cs_n, per_cs_n}));

    // R11
    invalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |-> (&{up_cs_n, lo_cs_n, mid_cs_n, per_cs_n}));
endmodule

// File: tb/csel_ready_gen_bench.sv
module csel_ready_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        bus_valid = 1'b0;
    logic        bus_start = 1'b0;
    logic        bus_io = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        ext_rdy = 1'b1;
    logic        up_cs_n, lo_cs_n, rdy;
    logic [3:0]  mid_cs_n;
    logic [6:0]  per_cs_n;

    always #2 clk = ~clk;

    csel_ready_gen u_csel_ready_gen (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_start(bus_start), .bus_io(bus_io), .bus_addr(bus_addr),
        .ext_rdy(ext_rdy), .up_cs_n(up_cs_n), .lo_cs_n(lo_cs_n),
        .mid_cs_n(mid_cs_n), .per_cs_n(per_cs_n), .rdy(rdy)
    );

    // cs vector bit order: 0 top, 1 lower, 2..5 mid quarters, 6..12 peripherals
    wire [12:0] cs_all = {per_cs_n, mid_cs_n, lo_cs_n, up_cs_n};
    localparam logic [12:0] NONE = 13'h1FFF;
    function automatic logic [12:0] act(input int b);
        return NONE & ~(13'd1 << b);
    endfunction

    typedef struct {
        int          mode;   // 0 selects, 1 ready, 2 read data
        logic [12:0] cs;
        logic        r;
        logic [15:0] rd;
        string       req;
    } exp_t;

    exp_t sb_q[$];
    event chk_ev;
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;

    // Monitor: pops expected items and compares them with the outputs.
    initial forever begin
        @(chk_ev);
        #1;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (e.mode == 0 && cs_all !== e.cs) begin
                failures++;
                $display("FAIL %s selects got=%h exp=%h", e.req, cs_all, e.cs);
            end else if (e.mode == 1 && rdy !== e.r) begin
                failures++;
                $display("FAIL %s rdy got=%b exp=%b", e.req, rdy, e.r);
            end else if (e.mode == 2 && reg_rdata !== e.rd) begin
                failures++;
                $display("FAIL %s rdata got=%h exp=%h", e.req, reg_rdata, e.rd);
            end
        end
    end

    task automatic push(input int mode, input logic [12:0] cs, input logic r,
                        input logic [15:0] rd, input string req);
        exp_t e;
        e.mode = mode; e.cs = cs; e.r = r; e.rd = rd; e.req = req;
        sb_q.push_back(e);
        -> chk_ev;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chk_rd(input logic [2:0] a, input logic [15:0] d, input string req);
        @(negedge clk);
        reg_addr = a;
        push(2, NONE, 1'b0, d, req);
    endtask

    task automatic chk_cs(input logic [19:0] a, input logic io, input logic v,
                          input logic [12:0] cs, input string req);
        @(negedge clk);
        bus_addr = a; bus_io = io; bus_valid = v;
        push(0, cs, 1'b0, '0, req);
    endtask

    task automatic launch(input logic [19:0] a, input logic io, input logic ext);
        @(negedge clk);
        bus_addr = a; bus_io = io; bus_valid = 1'b1; bus_start = 1'b1; ext_rdy = ext;
    endtask

    task automatic run_acc(input logic [19:0] a, input logic io, input int ws,
                           input string req);
        launch(a, io, 1'b1);
        for (int k = 0; k <= ws; k++) begin
            @(negedge clk);
            bus_start = 1'b0;
            push(1, NONE, (k == ws), '0, req);
        end
        @(negedge clk);
        push(1, NONE, 1'b0, '0, "R13");
    endtask

    initial begin
        #800000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        bus_valid = 1'b1; bus_addr = 20'hFFFFF;
        push(0, NONE, 1'b0, '0, "R1");
        push(1, NONE, 1'b0, '0, "R1");
        @(negedge clk);
        rst = 1'b0;

        chk_rd(3'd0, 16'hFFFB, "R2");
        chk_cs(20'hFFC00, 1'b0, 1'b1, act(0), "R2");
        chk_cs(20'hFFBFF, 1'b0, 1'b1, NONE, "R4");
        chk_cs(20'h00000, 1'b0, 1'b1, NONE, "R3");
        chk_cs(20'hFFC00, 1'b1, 1'b1, NONE, "R10");
        chk_cs(20'h00400, 1'b1, 1'b1, NONE, "R3");
        run_acc(20'hFFC00, 1'b0, 3, "R8");

        // R9: external ready honoured in the top region
        launch(20'hFFC00, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            bus_start = 1'b0;
            push(1, NONE, 1'b0, '0, "R9");
        end
        @(negedge clk);
        ext_rdy = 1'b1;
        push(1, NONE, 1'b1, '0, "R9");
        @(negedge clk);
        push(1, NONE, 1'b0, '0, "R13");

        // Lower region: pages 0..3, ignore external ready, 1 wait
        wr_reg(3'd1, 16'h00C5);
        chk_rd(3'd1, 16'h00C5, "R5");
        chk_cs(20'h00FFF, 1'b0, 1'b1, act(1), "R5");
        chk_cs(20'h01000, 1'b0, 1'b1, NONE, "R5");
        launch(20'h00010, 1'b0, 1'b0);
        @(negedge clk);
        bus_start = 1'b0;
        push(1, NONE, 1'b0, '0, "R9");
        @(negedge clk);
        push(1, NONE, 1'b1, '0, "R9");
        @(negedge clk);
        push(1, NONE, 1'b0, '0, "R13");
        ext_rdy = 1'b1;

        // Mid-range block at 0x20000
        wr_reg(3'd2, 16'h2000);
        chk_cs(20'h20000, 1'b0, 1'b1, NONE, "R3");
        wr_reg(3'd3, 16'h0002);
        chk_cs(20'h20000, 1'b0, 1'b1, act(2), "R6");
        chk_cs(20'h22000, 1'b0, 1'b1, act(3), "R6");
        chk_cs(20'h27FFF, 1'b0, 1'b1, act(5), "R6");
        chk_cs(20'h28000, 1'b0, 1'b1, NONE, "R6");

        // Peripheral windows at 0x00400 in IO space, ignore ext, 2 waits
        wr_reg(3'd4, 16'h0066);
        chk_cs(20'h00400, 1'b1, 1'b1, act(6), "R7");
        chk_cs(20'h00700, 1'b1, 1'b1, act(12), "R7");
        chk_cs(20'h00780, 1'b1, 1'b1, NONE, "R7");
        chk_cs(20'h00400, 1'b0, 1'b1, act(1), "R10");
        chk_cs(20'h00400, 1'b1, 1'b0, NONE, "R11");
        run_acc(20'h00480, 1'b1, 2, "R8");
        run_acc(20'h08000, 1'b1, 0, "R13");

        // Oversized code acts as 512K: block 0x00000..0x7FFFF
        wr_reg(3'd3, 16'h0007);
        chk_cs(20'h60000, 1'b0, 1'b1, act(5), "R6");
        chk_cs(20'h00010, 1'b0, 1'b1, act(1), "R10");

        // R12: write and bus start in the same clock
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 16'h00C7;
        bus_addr = 20'h00010; bus_io = 1'b0; bus_valid = 1'b1;
        bus_start = 1'b1; ext_rdy = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; bus_start = 1'b0;
        push(1, NONE, 1'b0, '0, "R12");
        @(negedge clk);
        push(1, NONE, 1'b1, '0, "R12");
        run_acc(20'h00010, 1'b0, 3, "R12");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule